// File: doc/BRIEF.md
# Half-Word to Word Register Bridge

This block joins a host bus that may issue 16-bit accesses to a register file that only accepts whole 32-bit words. With the bridge enabled, two half-word writes to the same word are gathered and sent to the register file as one 32-bit write. A half-word read fetches the whole word once and keeps a copy. The second half of that word is then served from the copy, so a register whose read has side effects is read only once per pair. Word accesses go straight through in either case.

A mode input selects the pairing path or the plain word path. A small configuration register is held inside the bridge. It reports the host bus width in bit 2 and keeps a masked set of writable bits. Requests take one cycle. The downstream port reads combinationally in the request cycle, and the host response is registered one cycle later.

Top module: `hword_bridge`

## Requirements
- R1: Only `addr_i[7:0]` is decoded; higher host address bits have no effect. Every downstream access uses the word-aligned address `{addr_i[7:2], 2'b00}`.
- R2: Each cycle with `req_i` high is answered by `rsp_valid_o` high in the next cycle, with `rsp_rdata_o` and `rsp_err_o` valid in that same cycle. Writes return 0 on `rsp_rdata_o`.
- R3: `size_i` encodes 2'b01 as half-word and 2'b10 as word. With `mode16_i`=1, a word access is forwarded at once with full 32-bit data and leaves the pairing state of both directions untouched.
- R4: A half-word write takes `wdata_i[15:0]` into the upper half when `addr_i[1]`=1 and into the lower half otherwise. The first half of a pair causes no downstream access.
- R5: The second half-word write to the same aligned address issues one downstream write of {upper half, lower half}, whichever half came first. It also clears the write pair count. If the same half is written twice, the other half keeps its last stored value.
- R6: A half-word write whose aligned address differs from that of the previous half-word write restarts pairing, so that write counts as a first half.
- R7: The first half-word read of a pair issues one downstream read and stores the word. It returns the selected half (upper when `addr_i[1]`=1) zero-extended on `rsp_rdata_o`.
- R8: The second half-word read to the same aligned address makes no downstream access. It is answered from the stored word and clears the read pair count.
- R9: Read pairing tracks its own previous aligned address and restarts when that address changes. Half-word writes never affect read pairing, and half-word reads never affect write pairing.
- R10: With `mode16_i`=1, sizes 2'b00 and 2'b11 give `rsp_err_o`=1 for that one response. They make no downstream access and change no pairing state.
- R11: With `mode16_i`=0, every access is forwarded as a 32-bit word whatever `size_i` is, and no error is raised.
- R12: The configuration word at offset 0x54 is handled inside the bridge and never appears downstream. It resets to 0x00050000, and bit 2 reads as the inverse of `mode16_i`. A write keeps only the bits in 0x0003F300 and cannot change bit 2.
- R13: Reset clears both pair counts, so the first half-word access of each direction after reset counts as a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode16_i | input | 1 | 1 selects half-word pairing, 0 the plain word path |
| req_i | input | 1 | Host access strobe, one cycle per access |
| we_i | input | 1 | 1 write, 0 read |
| size_i | input | 2 | Access size: 01 half-word, 10 word, others invalid |
| addr_i | input | HOST_AW (16) | Host byte address |
| wdata_i | input | 32 | Write data; half-word writes use bits 15:0 |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Unsupported access size |
| dn_req_o | output | 1 | Downstream word access strobe |
| dn_we_o | output | 1 | Downstream write enable |
| dn_addr_o | output | 8 | Downstream word-aligned address |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_rdata_i | input | 32 | Downstream read data, valid in the request cycle |

## Verification
Directed sequences send both half orders to one word. They tell real merging apart from a bridge that writes each half through or takes the halves from fixed positions. Pairs broken by an address change, by a word access in between, and by a reset separate a count that restarts from one that runs on. A read-counting register downstream shows whether a second half-word read reaches it again. Seeded random traffic then mixes modes, all four size codes, high address bits, and the configuration and side-effect offsets. It covers interleavings of the two directions that the directed cases do not.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/hwb_wr_pair.sv
module hwb_wr_pair
  import hwb_pkg::*;
#(
  parameter int unsigned WIN_AW = 8,
  localparam int unsigned IDX_W = WIN_AW - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upper_i,
  input  half_t            half_i,
  output logic             fire_o,
  output word_t            word_o
);
  logic [IDX_W-1:0] prev_q;
  logic             cnt_q;
  half_t            lo_q, hi_q;
  logic             have_one;

  // pair count only survives while the aligned address repeats
  assign have_one = cnt_q && (prev_q == idx_i);
  assign fire_o   = hw_we_i && have_one;
  assign word_o   = upper_i ? {half_i, lo_q} : {hi_q, half_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (hw_we_i) begin
      prev_q <= idx_i;
      cnt_q  <= ~have_one;
      if (upper_i) hi_q <= half_i;
      else         lo_q <= half_i;
    end
  end
endmodule

// File: rtl/hwb_rd_pair.sv
module hwb_rd_pair
  import hwb_pkg::*;
#(
  parameter int unsigned WIN_AW = 8,
  localparam int unsigned IDX_W = WIN_AW - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_re_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upper_i,
  input  word_t            word_i,
  output logic             fetch_o,
  output half_t            half_o
);
  logic [IDX_W-1:0] prev_q;
  logic             cnt_q;
  word_t            hold_q;
  word_t            src;
  logic             have_one;

  assign have_one = cnt_q && (prev_q == idx_i);
  assign fetch_o  = hw_re_i && !have_one;
  assign src      = fetch_o ? word_i : hold_q;
  assign half_o   = upper_i ? src[DATA_W-1:HALF_W] : src[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= 1'b0;
      hold_q <= '0;
    end else if (hw_re_i) begin
      prev_q <= idx_i;
      cnt_q  <= ~have_one;
      if (fetch_o) hold_q <= word_i;
    end
  end
endmodule

// File: rtl/hwb_cfg_reg.sv
module hwb_cfg_reg
  import hwb_pkg::*;
#(
  parameter word_t       RST_VAL   = 32'h0005_0000,
  parameter word_t       WR_MASK   = 32'h0003_F300,
  parameter int unsigned WIDTH_BIT = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  word_t wdata_i,
  input  logic  wide_i,
  output word_t rdata_o
);
  localparam word_t KEEP = WR_MASK & ~(word_t'(1) << WIDTH_BIT);

  word_t store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= RST_VAL & ~(word_t'(1) << WIDTH_BIT);
    else if (we_i) store_q <= wdata_i & KEEP;
  end

  always_comb begin
    rdata_o            = store_q;
    rdata_o[WIDTH_BIT] = wide_i;
  end
endmodule

// File: rtl/hword_bridge.sv
module hword_bridge
  import hwb_pkg::*;
#(
  parameter int unsigned HOST_AW   = 16,
  parameter int unsigned WIN_AW    = 8,
  parameter logic [7:0]  CFG_OFS   = 8'h54,
  parameter word_t       CFG_RST   = 32'h0005_0000,
  parameter word_t       CFG_MASK  = 32'h0003_F300,
  parameter int unsigned WIDTH_BIT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode16_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [31:0]        wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               rsp_err_o,
  output logic               dn_req_o,
  output logic               dn_we_o,
  output logic [WIN_AW-1:0]  dn_addr_o,
  output logic [31:0]        dn_wdata_o,
  input  logic [31:0]        dn_rdata_i
);
  localparam int unsigned IDX_W = WIN_AW - 2;
  localparam logic [IDX_W-1:0] CFG_IDX = CFG_OFS[WIN_AW-1:2];

  logic [IDX_W-1:0] idx;
  logic             upper;
  logic             is_half, is_word, bad;
  logic             direct, hw_we, hw_re;
  logic             fire, fetch;
  word_t            pair_word, acc_rdata, cfg_rdata, result;
  half_t            rd_half;
  logic             acc_v, acc_we, hit_cfg;
  word_t            acc_wdata;
  logic             unused_addr_hi;

  generate
    if (HOST_AW > WIN_AW) begin : g_hi
      assign unused_addr_hi = ^addr_i[HOST_AW-1:WIN_AW];
    end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  assign idx     = addr_i[WIN_AW-1:2];
  assign upper   = addr_i[1];
  assign is_half = size_i == SZ_HALF;
  assign is_word = size_i == SZ_WORD;
  assign bad     = req_i && mode16_i && !is_half && !is_word;
  assign direct  = req_i && (!mode16_i || is_word);
  assign hw_we   = req_i && mode16_i && is_half && we_i;
  assign hw_re   = req_i && mode16_i && is_half && !we_i;

  hwb_wr_pair #(.WIN_AW(WIN_AW)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_we_i (hw_we),
    .idx_i   (idx),
    .upper_i (upper),
    .half_i  (wdata_i[HALF_W-1:0]),
    .fire_o  (fire),
    .word_o  (pair_word)
  );

  hwb_rd_pair #(.WIN_AW(WIN_AW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_re_i (hw_re),
    .idx_i   (idx),
    .upper_i (upper),
    .word_i  (acc_rdata),
    .fetch_o (fetch),
    .half_o  (rd_half)
  );

  // one word access per cycle: direct, merged write, or first-half fetch
  assign acc_v     = direct || fire || fetch;
  assign acc_we    = direct ? we_i : fire;
  assign acc_wdata = direct ? wdata_i : pair_word;
  assign hit_cfg   = idx == CFG_IDX;

  hwb_cfg_reg #(
    .RST_VAL   (CFG_RST),
    .WR_MASK   (CFG_MASK),
    .WIDTH_BIT (WIDTH_BIT)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc_v && acc_we && hit_cfg),
    .wdata_i (acc_wdata),
    .wide_i  (!mode16_i),
    .rdata_o (cfg_rdata)
  );

  assign acc_rdata  = hit_cfg ? cfg_rdata : dn_rdata_i;
  assign dn_req_o   = acc_v && !hit_cfg;
  assign dn_we_o    = dn_req_o && acc_we;
  assign dn_addr_o  = {idx, 2'b00};
  assign dn_wdata_o = acc_wdata;

  always_comb begin
    result = '0;
    if (direct && !we_i) result = acc_rdata;
    else if (hw_re)      result = {{HALF_W{1'b0}}, rd_half};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rsp_err_o   <= bad;
      rsp_rdata_o <= result;
    end
  end
endmodule

// File: rtl/hword_bridge_chk.sv
module hword_bridge_chk #(
  parameter int unsigned WIN_AW  = 8,
  parameter logic [7:0]  CFG_OFS = 8'h54
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode16_i,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              dn_req_o,
  input logic              dn_we_o,
  input logic [WIN_AW-1:0] dn_addr_o
);
  logic bad_size;
  assign bad_size = size_i == 2'b00 || size_i == 2'b11;

  assert_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> dn_addr_o[1:0] == 2'b00);

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  assert_no_spurious_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> req_i);

  assert_word_write_passes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode16_i && size_i == 2'b10 && we_i && dn_req_o |-> dn_we_o);

  assert_err_no_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode16_i && bad_size |-> !dn_req_o);

  assert_err_flagged_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode16_i && bad_size |=> rsp_err_o);

  assert_err_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o);

  assert_plain_no_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !mode16_i |=> !rsp_err_o);

  assert_plain_forwards_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !mode16_i && dn_addr_o[WIN_AW-1:2] != CFG_OFS[WIN_AW-1:2] |-> dn_req_o && dn_we_o == we_i);

  assert_cfg_local_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> dn_addr_o[WIN_AW-1:2] != CFG_OFS[WIN_AW-1:2]);
endmodule

bind hword_bridge hword_bridge_chk #(
  .WIN_AW  (WIN_AW),
  .CFG_OFS (CFG_OFS)
) u_chk (.*);

// File: tb/hword_bridge_test.sv
`timescale 1ns/1ps
module hword_bridge_test;
  localparam int unsigned HOST_AW = 16;
  localparam logic [5:0] CFG_W  = 6'h15; // offset 0x54
  localparam logic [5:0] SIDE_W = 6'h10; // offset 0x40, counts reads
  localparam logic [31:0] MASK  = 32'h0003_F300;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode16_i = 1'b1;
  logic req_i = 1'b0;
  logic we_i = 1'b0;
  logic [1:0] size_i = 2'b10;
  logic [HOST_AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic rsp_valid_o, rsp_err_o, dn_req_o, dn_we_o;
  logic [31:0] rsp_rdata_o, dn_wdata_o, dn_rdata_i;
  logic [7:0] dn_addr_o;

  always #2 clk_i = ~clk_i;

  hword_bridge uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode16_i(mode16_i), .req_i(req_i),
    .we_i(we_i), .size_i(size_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .dn_req_o(dn_req_o), .dn_we_o(dn_we_o), .dn_addr_o(dn_addr_o),
    .dn_wdata_o(dn_wdata_o), .dn_rdata_i(dn_rdata_i)
  );

  // downstream register file model
  logic [31:0] mem [64];
  logic [31:0] side_cnt = '0;
  int n_dnw = 0, n_dnr = 0;
  assign dn_rdata_i = (dn_addr_o[7:2] == SIDE_W) ? side_cnt : mem[dn_addr_o[7:2]];
  always @(posedge clk_i) begin
    if (dn_req_o) begin
      if (dn_we_o) begin
        n_dnw <= n_dnw + 1;
        if (dn_addr_o[7:2] != SIDE_W) mem[dn_addr_o[7:2]] <= dn_wdata_o;
      end else begin
        n_dnr <= n_dnr + 1;
        if (dn_addr_o[7:2] == SIDE_W) side_cnt <= side_cnt + 1;
      end
    end
  end

  // reference state
  logic [31:0] exp_mem [64];
  logic [31:0] exp_side = '0;
  logic [31:0] m_cfg, m_hold;
  logic [15:0] m_lo, m_hi;
  logic [5:0]  m_wprev, m_rprev;
  int m_wcnt, m_rcnt;
  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_cfg = 32'h0005_0000; m_hold = '0; m_lo = '0; m_hi = '0;
    m_wprev = '0; m_rprev = '0; m_wcnt = 0; m_rcnt = 0;
  endtask

  task automatic mdl_rd(input logic [5:0] w, input bit m16, output logic [31:0] v);
    if (w == CFG_W) v = m_cfg | (m16 ? 32'h0 : 32'h4);
    else if (w == SIDE_W) begin v = exp_side; exp_side = exp_side + 1; end
    else v = exp_mem[w];
  endtask

  task automatic mdl_wr(input logic [5:0] w, input logic [31:0] d);
    if (w == CFG_W) m_cfg = d & MASK;
    else if (w != SIDE_W) exp_mem[w] = d;
  endtask

  // one host access; called at a falling edge, returns at the next one
  task automatic op(input bit m16, input bit we, input logic [1:0] sz,
                    input logic [HOST_AW-1:0] a, input logic [31:0] wd, input string req);
    logic [5:0] w;
    logic [31:0] e_rd;
    bit e_err;
    w = a[7:2]; e_rd = '0; e_err = 1'b0;
    if (!m16 || sz == 2'b10) begin
      if (we) mdl_wr(w, wd); else mdl_rd(w, m16, e_rd);
    end else if (sz == 2'b01) begin
      if (we) begin
        if (w != m_wprev) m_wcnt = 0;
        m_wprev = w;
        if (a[1]) m_hi = wd[15:0]; else m_lo = wd[15:0];
        m_wcnt++;
        if (m_wcnt == 2) begin m_wcnt = 0; mdl_wr(w, {m_hi, m_lo}); end
      end else begin
        if (w != m_rprev) m_rcnt = 0;
        m_rprev = w;
        m_rcnt++;
        if (m_rcnt == 1) mdl_rd(w, m16, m_hold); else m_rcnt = 0;
        e_rd = a[1] ? {16'h0, m_hold[31:16]} : {16'h0, m_hold[15:0]};
      end
    end else e_err = 1'b1;
    mode16_i = m16; req_i = 1'b1; we_i = we; size_i = sz; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    check(rsp_valid_o === 1'b1, "R2", {31'h0, rsp_valid_o}, 32'h1);
    check(rsp_err_o === e_err, req, {31'h0, rsp_err_o}, {31'h0, e_err});
    check(rsp_rdata_o === e_rd, req, rsp_rdata_o, e_rd);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    mdl_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int w0, r0;
    logic [31:0] rnd;
    for (int i = 0; i < 64; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    mdl_reset();
    repeat (3) @(negedge clk_i);
    check(rsp_valid_o === 1'b0 && rsp_err_o === 1'b0, "R2", {30'h0, rsp_valid_o, rsp_err_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rsp_valid_o === 1'b0, "R2", {31'h0, rsp_valid_o}, 32'h0);

    // R12 reset value and width bit
    op(1, 0, 2'b10, 16'h0054, 0, "R12");
    op(0, 0, 2'b10, 16'h0054, 0, "R12");
    op(1, 1, 2'b10, 16'h0054, 32'hFFFF_FFFF, "R12");
    op(1, 0, 2'b10, 16'h0054, 0, "R12");
    op(0, 0, 2'b10, 16'h0054, 0, "R12");

    // R4 R5 low then high
    w0 = n_dnw;
    op(1, 1, 2'b01, 16'h0010, 32'hDEAD_1234, "R4");
    check(n_dnw == w0, "R4", n_dnw - w0, 0);
    op(1, 1, 2'b01, 16'h0012, 32'h0000_ABCD, "R5");
    check(n_dnw == w0 + 1, "R5", n_dnw - w0, 1);
    op(1, 0, 2'b10, 16'h0010, 0, "R5");
    // high then low
    op(1, 1, 2'b01, 16'h0016, 32'h0000_5555, "R5");
    op(1, 1, 2'b01, 16'h0014, 32'h0000_6666, "R5");
    op(1, 0, 2'b10, 16'h0014, 0, "R5");

    // R6 restart on address change
    w0 = n_dnw;
    op(1, 1, 2'b01, 16'h0020, 32'h0000_1111, "R6");
    op(1, 1, 2'b01, 16'h0026, 32'h0000_2222, "R6");
    check(n_dnw == w0, "R6", n_dnw - w0, 0);
    op(1, 1, 2'b01, 16'h0024, 32'h0000_3333, "R6");
    check(n_dnw == w0 + 1, "R6", n_dnw - w0, 1);

    // R3 word access between halves does not disturb pairing; R1 high bits
    op(1, 1, 2'b01, 16'h0030, 32'h0000_AAAA, "R3");
    op(1, 1, 2'b10, 16'hF030, 32'h1357_9BDF, "R1");
    w0 = n_dnw;
    op(1, 1, 2'b01, 16'h7032, 32'h0000_BBBB, "R3");
    check(n_dnw == w0 + 1, "R3", n_dnw - w0, 1);
    op(1, 0, 2'b10, 16'h0030, 0, "R3");

    // R7 R8 read-once register
    r0 = n_dnr;
    op(1, 0, 2'b01, 16'h0042, 0, "R7");
    check(n_dnr == r0 + 1, "R7", n_dnr - r0, 1);
    op(1, 0, 2'b01, 16'h0040, 0, "R8");
    check(n_dnr == r0 + 1, "R8", n_dnr - r0, 1);
    op(1, 0, 2'b01, 16'h0040, 0, "R7");
    check(n_dnr == r0 + 2, "R7", n_dnr - r0, 2);

    // R9 interleaved directions, read restart
    op(1, 1, 2'b01, 16'h0010, 32'h0000_7777, "R9");
    op(1, 0, 2'b01, 16'h0042, 0, "R9");
    r0 = n_dnr;
    op(1, 0, 2'b01, 16'h0012, 0, "R9");
    check(n_dnr == r0 + 1, "R9", n_dnr - r0, 1);
    op(1, 1, 2'b01, 16'h0012, 32'h0000_8888, "R9");
    op(1, 0, 2'b10, 16'h0010, 0, "R9");

    // R10 bad sizes
    w0 = n_dnw; r0 = n_dnr;
    op(1, 1, 2'b00, 16'h0004, 32'hFFFF_FFFF, "R10");
    op(1, 0, 2'b11, 16'h0004, 0, "R10");
    check(n_dnw == w0 && n_dnr == r0, "R10", n_dnw + n_dnr - w0 - r0, 0);
    op(1, 0, 2'b10, 16'h0004, 0, "R10");

    // R11 plain mode ignores size
    op(0, 1, 2'b01, 16'h0008, 32'hCAFE_F00D, "R11");
    op(0, 0, 2'b00, 16'h000A, 0, "R11");
    op(0, 0, 2'b11, 16'h0008, 0, "R11");

    // R13 reset mid-pair at aligned address 0
    op(1, 1, 2'b01, 16'h0000, 32'h0000_4444, "R13");
    op(1, 0, 2'b01, 16'h0000, 0, "R13");
    do_reset();
    w0 = n_dnw; r0 = n_dnr;
    op(1, 1, 2'b01, 16'h0002, 32'h0000_9999, "R13");
    check(n_dnw == w0, "R13", n_dnw - w0, 0);
    op(1, 0, 2'b01, 16'h0002, 0, "R13");
    check(n_dnr == r0 + 1, "R13", n_dnr - r0, 1);

    // seeded random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [HOST_AW-1:0] a;
      logic [1:0] sz;
      bit m16;
      rnd = $urandom();
      case (rnd[3:0])
        4'd0:    a = 16'h0040;
        4'd1:    a = 16'h0054;
        4'd2:    a = 16'h0042;
        default: a = {8'h00, 3'b000, rnd[6:4], rnd[8:7], 2'b00} | {15'h0, 1'b0};
      endcase
      a[1] = rnd[9];
      a[15:8] = rnd[31:24];
      m16 = rnd[13:10] != 4'd0;
      sz = (rnd[16:14] < 3'd5) ? 2'b01 : (rnd[16:14] < 3'd7 ? 2'b10 : rnd[18:17]);
      op(m16, rnd[19], sz, a, $urandom(), "R5");
    end

    // final downstream contents
    @(negedge clk_i);
    for (int i = 0; i < 64; i++)
      if (i != SIDE_W) check(mem[i] === exp_mem[i], "R5", mem[i], exp_mem[i]);
    check(side_cnt === exp_side, "R8", side_cnt, exp_side);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule